// File: doc/BRIEF.md
# Receive Ring Frame Writer

This block takes an incoming Ethernet frame, one byte per cycle, with start, valid and last markers. It decides whether the frame is wanted by looking at its destination address. Accepted frames go into a circular buffer made of 256-byte pages, through a byte-wide memory write port. The start page, the stop page (one past the last page), the host boundary page and the receive configuration come from the register block. The block owns the current page. The host can load a new value, and each accepted frame moves it forward.

Every stored frame takes one or more whole pages. The first four bytes of its first page hold a header: status, next page, and the length as a low byte then a high byte. The frame bytes follow from offset 4 and wrap from the stop page back to the start page. The full length is only known at the end of the frame, so the data is written first and the header afterwards. A one-cycle done pulse marks the cycle in which the last header byte is written. A frame is refused outright when the controller is stopped or the ring lacks room.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `cur_page` is 0, `rx_done` is 0 and `mem_we` is 0.
- R2: A `cur_load` pulse while no frame is in progress sets `cur_page` to `cur_load_pg` on the next cycle. `cur_page` changes otherwise only together with `rx_done`.
- R3: A frame that starts while `ctrl_stopped` is 1 causes no memory write and no `rx_done`, and leaves `cur_page` unchanged.
- R4: Free bytes are computed at frame start as follows. If current < boundary, free bytes = (boundary − current)·256. Otherwise free bytes = ((stop − start) − (current − boundary))·256. When fewer than 1518 bytes are free, the frame is refused with no memory write.
- R5: With promiscuous mode off, a destination whose first byte has bit 0 clear is accepted only if destination byte k equals `station_mac[8k+7:8k]` for every k from 0 to 5.
- R6: An all-ones destination is accepted only when `cfg_bcast_en` is 1.
- R7: Any other destination whose first byte has bit 0 set is a group address. It is accepted only when `cfg_mcast_en` is 1 and `mcast_table[i]` is 1. The index i is computed by a 32-bit register that starts at all ones and takes the 48 destination bits in order: byte 0 first, least significant bit first within each byte. For each bit, the register shifts left by one. If the bit shifted out, XORed with the data bit, is 1, the register is then XORed with 0x04C11DB7. After the last bit, i is the top 6 bits of the register.
- R8: With `cfg_promisc` set to 1, every frame that passes R3 and R4 is accepted.
- R9: A frame shorter than 60 bytes is extended with zero bytes to 60 stored bytes.
- R10: For an accepted frame with S stored bytes, the header sits at page base B = `cur_page`·256. B+0 holds the status: 0x01, or 0x21 for a group destination. B+1 holds the next page. B+2 and B+3 hold S+4, low byte first. The header is written after all data, and `rx_done` is high in the same cycle that B+3 is written.
- R11: Stored byte n goes to address B+4+n. The address moves back to start·256 whenever it reaches stop·256.
- R12: The next page is current + ceil((S+8)/256). If that value is at or beyond the stop page, (stop − start) is subtracted. `cur_page` takes this value together with a one-cycle `rx_done` pulse.
- R13: A frame rejected by the address filter writes no header, raises no `rx_done` and leaves `cur_page` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_stopped | input | 1 | Controller stopped; frames are refused |
| cfg_promisc | input | 1 | Accept every destination |
| cfg_bcast_en | input | 1 | Accept the all-ones destination |
| cfg_mcast_en | input | 1 | Accept group destinations that hit the hash table |
| station_mac | input | 48 | Station address, byte 0 in bits 7:0 |
| mcast_table | input | 64 | Group hash filter, one bit per index |
| ring_first_pg | input | 8 | First page of the ring |
| ring_end_pg | input | 8 | Page one past the end of the ring |
| host_bnd_pg | input | 8 | Boundary page owned by the host |
| cur_load | input | 1 | Load the current page |
| cur_load_pg | input | 8 | Value for the current page load |
| rx_first | input | 1 | Byte is the first of a frame |
| rx_valid | input | 1 | Byte is valid |
| rx_last | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Frame byte |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | 16 | Buffer byte address |
| mem_wdata | output | 8 | Buffer write data |
| cur_page | output | 8 | Current page |
| rx_done | output | 1 | One-cycle pulse when a frame is committed |

## Verification
A wrong write pointer shows up at the memory port at once. A misplaced byte lands outside B+4+n, or outside the ring after the stop page. A filter or room decision that is wrong shows within one frame time: the header writes and the `rx_done` pulse either appear or go missing, and `cur_page` moves or stays put. A wrong length count or next-page value is held in the header and in `cur_page` until the next frame, so the bench reads them back from its memory model and from the port after every frame.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_DROP,
    ST_PAD,
    ST_DECIDE,
    ST_HDR
  } rxw_state_e;

  localparam logic [7:0] STAT_GOOD  = 8'h01;
  localparam logic [7:0] STAT_GROUP = 8'h20;
  localparam int HDR_BYTES  = 4;
  localparam int CRC_BYTES  = 4;
  localparam int PAGE_SHIFT = 8;
  localparam int MAC_BYTES  = 6;
endpackage

// File: rtl/rxw_filter.sv
module rxw_filter #(
  parameter int HASH_BITS = 6,
  localparam int TBL_W = 2 ** HASH_BITS
) (
  input  logic [47:0]      dst,
  input  logic [47:0]      station,
  input  logic [TBL_W-1:0] table_bits,
  input  logic             promisc,
  input  logic             bcast_en,
  input  logic             mcast_en,
  output logic             accept
);
  function automatic logic [HASH_BITS-1:0] hash_of(input logic [47:0] a);
    logic [31:0] c;
    logic        fb;
    c = '1;
    for (int i = 0; i < 48; i++) begin
      fb = c[31] ^ a[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c[31 -: HASH_BITS];
  endfunction

  logic [HASH_BITS-1:0] idx;
  logic is_bcast, is_group;

  always_comb begin
    idx      = hash_of(dst);
    is_bcast = &dst;
    is_group = dst[0];
    if (promisc)       accept = 1'b1;
    else if (is_bcast) accept = bcast_en;
    else if (is_group) accept = mcast_en && table_bits[idx];
    else               accept = (dst == station);
  end
endmodule

// File: rtl/rxw_ring_calc.sv
module rxw_ring_calc #(
  parameter int PAGE_W     = 8,
  parameter int LEN_W      = 16,
  parameter int ROOM_BYTES = 1518
) (
  input  logic [PAGE_W-1:0] first_pg,
  input  logic [PAGE_W-1:0] end_pg,
  input  logic [PAGE_W-1:0] bnd_pg,
  input  logic [PAGE_W-1:0] cur_pg,
  input  logic [LEN_W-1:0]  stored_len,
  output logic              has_room,
  output logic [PAGE_W-1:0] next_pg
);
  import rxw_pkg::*;
  localparam int SW = LEN_W + 2;
  localparam int AW = PAGE_W + 1 + PAGE_SHIFT;
  localparam int ROUND = HDR_BYTES + CRC_BYTES + (2 ** PAGE_SHIFT) - 1;

  logic [PAGE_W:0] span_pg, used_pg, avail_pg;
  logic [SW-1:0]   total, pages, sum, wrapped;

  always_comb begin
    span_pg = {1'b0, end_pg} - {1'b0, first_pg};
    used_pg = '0;
    if (cur_pg < bnd_pg) begin
      avail_pg = {1'b0, bnd_pg} - {1'b0, cur_pg};
    end else begin
      used_pg  = {1'b0, cur_pg} - {1'b0, bnd_pg};
      avail_pg = span_pg - used_pg;
    end
    has_room = {avail_pg, {PAGE_SHIFT{1'b0}}} >= AW'(ROOM_BYTES);

    total   = {2'b00, stored_len} + SW'(ROUND);
    pages   = total >> PAGE_SHIFT;
    sum     = SW'(cur_pg) + pages;
    wrapped = (sum >= SW'(end_pg)) ? (sum - SW'(span_pg)) : sum;
    next_pg = wrapped[PAGE_W-1:0];
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int PAGE_W     = 8,
  parameter int LEN_W      = 16,
  parameter int MIN_FRAME  = 60,
  parameter int ROOM_BYTES = 1518,
  parameter int HASH_BITS  = 6,
  localparam int ADDR_W = PAGE_W + 8,
  localparam int TBL_W  = 2 ** HASH_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_stopped,
  input  logic              cfg_promisc,
  input  logic              cfg_bcast_en,
  input  logic              cfg_mcast_en,
  input  logic [47:0]       station_mac,
  input  logic [TBL_W-1:0]  mcast_table,
  input  logic [PAGE_W-1:0] ring_first_pg,
  input  logic [PAGE_W-1:0] ring_end_pg,
  input  logic [PAGE_W-1:0] host_bnd_pg,
  input  logic              cur_load,
  input  logic [PAGE_W-1:0] cur_load_pg,
  input  logic              rx_first,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic [7:0]        rx_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [PAGE_W-1:0] cur_page,
  output logic              rx_done
);
  import rxw_pkg::*;

  rxw_state_e        state;
  logic [ADDR_W-1:0] wr_addr, addr_inc;
  logic [LEN_W-1:0]  cnt;
  logic [47:0]       dst;
  logic [1:0]        hdr_idx;
  logic [PAGE_W-1:0] cur_q, next_pg;
  logic              has_room, accept;
  logic              st_en;
  logic [7:0]        st_byte, hdr_byte;
  logic [15:0]       len_field;
  logic [ADDR_W-1:0] first_base, end_base;

  rxw_filter #(.HASH_BITS(HASH_BITS)) u_filter (
    .dst(dst), .station(station_mac), .table_bits(mcast_table),
    .promisc(cfg_promisc), .bcast_en(cfg_bcast_en), .mcast_en(cfg_mcast_en),
    .accept(accept)
  );

  rxw_ring_calc #(.PAGE_W(PAGE_W), .LEN_W(LEN_W), .ROOM_BYTES(ROOM_BYTES)) u_calc (
    .first_pg(ring_first_pg), .end_pg(ring_end_pg), .bnd_pg(host_bnd_pg),
    .cur_pg(cur_q), .stored_len(cnt), .has_room(has_room), .next_pg(next_pg)
  );

  always_comb begin
    first_base = {ring_first_pg, 8'h00};
    end_base   = {ring_end_pg, 8'h00};
    addr_inc   = ((wr_addr + ADDR_W'(1)) == end_base) ? first_base : (wr_addr + ADDR_W'(1));
    st_en      = ((state == ST_DATA) && rx_valid) || (state == ST_PAD);
    st_byte    = (state == ST_PAD) ? 8'h00 : rx_data;
    len_field  = 16'(cnt + LEN_W'(HDR_BYTES));
    case (hdr_idx)
      2'd0:    hdr_byte = dst[0] ? (STAT_GOOD | STAT_GROUP) : STAT_GOOD;
      2'd1:    hdr_byte = 8'(next_pg);
      2'd2:    hdr_byte = len_field[7:0];
      default: hdr_byte = len_field[15:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wr_addr   <= '0;
      cnt       <= '0;
      dst       <= '0;
      hdr_idx   <= '0;
      cur_q     <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rx_done   <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      rx_done <= 1'b0;
      if (st_en) begin
        mem_we    <= 1'b1;
        mem_addr  <= wr_addr;
        mem_wdata <= st_byte;
        wr_addr   <= addr_inc;
        cnt       <= cnt + LEN_W'(1);
        if (cnt < LEN_W'(MAC_BYTES)) dst[{cnt[2:0], 3'b000} +: 8] <= st_byte;
      end
      case (state)
        ST_IDLE: begin
          if (cur_load) cur_q <= cur_load_pg;
          if (rx_valid && rx_first) begin
            if (ctrl_stopped || !has_room) begin
              state <= rx_last ? ST_IDLE : ST_DROP;
            end else begin
              mem_we    <= 1'b1;
              mem_addr  <= {cur_q, 8'(HDR_BYTES)};
              mem_wdata <= rx_data;
              wr_addr   <= {cur_q, 8'(HDR_BYTES + 1)};
              cnt       <= LEN_W'(1);
              dst       <= {40'h0, rx_data};
              state     <= rx_last ? ST_PAD : ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (rx_valid && rx_last)
            state <= ((cnt + LEN_W'(1)) < LEN_W'(MIN_FRAME)) ? ST_PAD : ST_DECIDE;
        end
        ST_DROP: begin
          if (rx_valid && rx_last) state <= ST_IDLE;
        end
        ST_PAD: begin
          if ((cnt + LEN_W'(1)) >= LEN_W'(MIN_FRAME)) state <= ST_DECIDE;
        end
        ST_DECIDE: begin
          hdr_idx <= 2'd0;
          state   <= accept ? ST_HDR : ST_IDLE;
        end
        ST_HDR: begin
          mem_we    <= 1'b1;
          mem_addr  <= {cur_q, 6'b000000, hdr_idx};
          mem_wdata <= hdr_byte;
          hdr_idx   <= hdr_idx + 2'd1;
          if (hdr_idx == 2'd3) begin
            cur_q   <= next_pg;
            rx_done <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cur_page = cur_q;

  // R11
  ring_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && (ring_first_pg < ring_end_pg)) |->
      ((mem_addr >= first_base) && (mem_addr < end_base)));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);

  // R2
  cur_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_page != $past(cur_page)) |-> (rx_done || $past(cur_load)));

  // R3
  stop_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && rx_valid && rx_first && ctrl_stopped) |=> !mem_we);

  // R10
  hdr_last_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> (mem_we && (mem_addr[7:0] == 8'h03)));
endmodule

// File: tb/test_rx_ring_writer.sv
module test_rx_ring_writer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        ctrl_stopped = 0, cfg_promisc = 0, cfg_bcast_en = 0, cfg_mcast_en = 0;
  logic [47:0] station_mac = {8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02};
  logic [63:0] mcast_table = '0;
  logic [7:0]  ring_first_pg = 8'h40, ring_end_pg = 8'h80, host_bnd_pg = 8'h40;
  logic        cur_load = 0;
  logic [7:0]  cur_load_pg = 0;
  logic        rx_first = 0, rx_valid = 0, rx_last = 0;
  logic [7:0]  rx_data = 0;
  logic        mem_we, rx_done;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, cur_page;

  rx_ring_writer i_rx_ring_writer (
    .clk(clk), .rst(rst), .ctrl_stopped(ctrl_stopped), .cfg_promisc(cfg_promisc),
    .cfg_bcast_en(cfg_bcast_en), .cfg_mcast_en(cfg_mcast_en), .station_mac(station_mac),
    .mcast_table(mcast_table), .ring_first_pg(ring_first_pg), .ring_end_pg(ring_end_pg),
    .host_bnd_pg(host_bnd_pg), .cur_load(cur_load), .cur_load_pg(cur_load_pg),
    .rx_first(rx_first), .rx_valid(rx_valid), .rx_last(rx_last), .rx_data(rx_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cur_page(cur_page), .rx_done(rx_done)
  );

  logic [7:0]  mem [0:65535];
  logic [7:0]  fb [0:1599];
  int          wr_cnt = 0, done_cnt = 0, base_hits = 0;
  logic [15:0] watch_addr = 16'hFFFF;
  int          errors = 0, checks = 0;
  bit          finished = 0;

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
      if (mem_addr == watch_addr) base_hits <= base_hits + 1;
    end
    if (rx_done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int hash_ref(input logic [47:0] d);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] v = d[8*b +: 8];
      for (int j = 0; j < 8; j++) begin
        logic carry = c[31] ^ v[0];
        c = c << 1;
        if (carry) c = (c ^ 32'h04C11DB6) | 32'h1;
        v = v >> 1;
      end
    end
    return int'(c[31:26]);
  endfunction

  task automatic fill(input logic [47:0] d, input int len);
    for (int i = 0; i < len; i++) fb[i] = (i < 6) ? d[8*i +: 8] : 8'((i * 7 + 3) & 8'hFF);
  endtask

  task automatic send(input int len, input bit gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 5 == 4)) begin
        rx_valid = 0; rx_first = 0; rx_last = 0;
        @(negedge clk);
      end
      rx_valid = 1; rx_first = (i == 0); rx_last = (i == len - 1); rx_data = fb[i];
      @(negedge clk);
    end
    rx_valid = 0; rx_first = 0; rx_last = 0;
    repeat (100) @(negedge clk);
  endtask

  int d0, w0, h0;
  task automatic start_frame(input logic [7:0] cur, input logic [7:0] bnd);
    cur_load = 1; cur_load_pg = cur;
    @(negedge clk);
    cur_load = 0;
    @(negedge clk);
    chk(cur_page == cur, "R2 cur_load", cur_page, cur);
    host_bnd_pg = bnd;
    watch_addr = {cur, 8'h00};
    d0 = done_cnt; w0 = wr_cnt; h0 = base_hits;
  endtask

  task automatic expect_accept(input string tag, input int len, input logic [7:0] cur);
    int st = (len < 60) ? 60 : len;
    int hl = st + 4;
    int nx = cur + (hl + 4 + 255) / 256;
    int bad = 0;
    int a = {cur, 8'h04};
    logic [7:0] stat = fb[0][0] ? 8'h21 : 8'h01;
    if (nx >= ring_end_pg) nx = nx - (ring_end_pg - ring_first_pg);
    chk(mem[{cur, 8'h00}] == stat, {tag, " R10 status"}, mem[{cur, 8'h00}], stat);
    chk(mem[{cur, 8'h01}] == 8'(nx), {tag, " R12 next field"}, mem[{cur, 8'h01}], nx);
    chk({mem[{cur, 8'h03}], mem[{cur, 8'h02}]} == 16'(hl), {tag, " R10 length"},
        {mem[{cur, 8'h03}], mem[{cur, 8'h02}]}, hl);
    for (int i = 0; i < st; i++) begin
      logic [7:0] e = (i < len) ? fb[i] : 8'h00;
      if (mem[16'(a)] !== e) bad++;
      a++;
      if (a == {ring_end_pg, 8'h00}) a = {ring_first_pg, 8'h00};
    end
    chk(bad == 0, {tag, " R11 R9 data"}, bad, 0);
    chk(cur_page == 8'(nx), {tag, " R12 cur_page"}, cur_page, nx);
    chk(done_cnt - d0 == 1, {tag, " R12 done"}, done_cnt - d0, 1);
  endtask

  task automatic expect_reject(input string tag, input logic [7:0] cur, input bit no_write);
    chk(cur_page == cur, {tag, " R13 cur_page"}, cur_page, cur);
    chk(done_cnt == d0, {tag, " R13 done"}, done_cnt - d0, 0);
    chk(base_hits == h0, {tag, " R13 header"}, base_hits - h0, 0);
    if (no_write) chk(wr_cnt == w0, {tag, " no write"}, wr_cnt - w0, 0);
  endtask

  task automatic t_reset();
    chk(cur_page == 0, "R1 cur_page", cur_page, 0);
    chk(rx_done == 0, "R1 rx_done", rx_done, 0);
    chk(mem_we == 0, "R1 mem_we", mem_we, 0);
  endtask

  task automatic t_unicast();
    fill(station_mac, 64); start_frame(8'h40, 8'h40); send(64, 0);
    expect_accept("R5 match", 64, 8'h40);
    fill({8'h56, station_mac[39:0]}, 64); start_frame(8'h41, 8'h41); send(64, 0);
    expect_reject("R5 mismatch", 8'h41, 0);
  endtask

  task automatic t_broadcast();
    fill('1, 70); start_frame(8'h42, 8'h42); send(70, 0);
    expect_reject("R6 bcast off", 8'h42, 0);
    cfg_bcast_en = 1;
    start_frame(8'h42, 8'h42); send(70, 0);
    expect_accept("R6 bcast on", 70, 8'h42);
    cfg_bcast_en = 0;
  endtask

  task automatic t_multicast();
    logic [47:0] g = {8'h01, 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01};
    int idx = hash_ref(g);
    cfg_mcast_en = 1; mcast_table = 64'h1 << idx;
    fill(g, 80); start_frame(8'h50, 8'h50); send(80, 0);
    expect_accept("R7 hash hit", 80, 8'h50);
    mcast_table = ~(64'h1 << idx);
    start_frame(8'h51, 8'h51); send(80, 0);
    expect_reject("R7 hash miss", 8'h51, 0);
    cfg_mcast_en = 0; mcast_table = '1;
    start_frame(8'h51, 8'h51); send(80, 0);
    expect_reject("R7 group off", 8'h51, 0);
    mcast_table = '0;
  endtask

  task automatic t_promisc();
    cfg_promisc = 1;
    fill(48'h0000_9988_7766, 100); start_frame(8'h52, 8'h52); send(100, 1);
    expect_accept("R8 promisc gaps", 100, 8'h52);
    cfg_promisc = 0;
  endtask

  task automatic t_short();
    fill(station_mac, 20); start_frame(8'h53, 8'h53); send(20, 0);
    expect_accept("R9 short pad", 20, 8'h53);
  endtask

  task automatic t_wrap();
    fill(station_mac, 300); start_frame(8'h7F, 8'h60); send(300, 0);
    expect_accept("R11 R12 wrap", 300, 8'h7F);
  endtask

  task automatic t_room();
    fill(station_mac, 64);
    start_frame(8'h40, 8'h45); send(64, 0);
    expect_reject("R4 room below", 8'h40, 1);
    start_frame(8'h40, 8'h46); send(64, 0);
    expect_accept("R4 room exact", 64, 8'h40);
    start_frame(8'h7C, 8'h41); send(64, 0);
    expect_reject("R4 room wrapped below", 8'h7C, 1);
    start_frame(8'h7C, 8'h42); send(64, 0);
    expect_accept("R4 room wrapped ok", 64, 8'h7C);
  endtask

  task automatic t_stopped();
    ctrl_stopped = 1;
    fill(station_mac, 64); start_frame(8'h60, 8'h60); send(64, 0);
    expect_reject("R3 stopped", 8'h60, 1);
    ctrl_stopped = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_unicast();
    t_broadcast();
    t_multicast();
    t_promisc();
    t_short();
    t_wrap();
    t_room();
    t_stopped();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule